// File: doc/BRIEF.md
# Parallel NOR Flash Command Interpreter

This block models the device side of an 8-bit parallel NOR flash that has eight equal sectors. The synchronous bus has a chip select, a write strobe, a read strobe, a 19-bit byte address, and separate data-in and data-out buses. Writes go through an unlock state machine that recognises the program, chip erase and sector erase command sequences. Commands are matched on the low 11 address bits only. Any write that breaks a sequence returns the machine to read mode.

A program or erase occupies the device for a busy time set by a parameter. A sector erase first opens a short collection window, in which more sector addresses can be queued. While an operation runs, reads return a status byte instead of array data. The status byte carries an inverted data bit, a toggle bit, an error flag and an erase-started flag. A program that tries to raise a cleared bit leaves the device in an error state until a reset command is written. The storage is shrunk by a parameter so that simulation stays fast. The sector is always taken from address bits 18..16, and the byte within the sector from the low `SEC_AW` bits.

Top module: `nor_cmd_flash`

## Requirements
- R1: The write sequence AA@555, 55@2AA, A0@555, then data D at address X programs X. When the busy phase ends, the byte at X reads as its old value AND D.
- R2: Reads are sampled on a rising clock edge. Take the final write of a program as edge 0. A read sampled at edges 1 to BUSY_CYC returns status. A read sampled at edge BUSY_CYC+1 or later returns array data.
- R3: Writing F0 while a command sequence is partly entered, or while in the error state, returns the device to read mode. A following lone A0@555 and data write do not program.
- R4: A write whose data or address does not match the next expected unlock step returns the machine to read mode. The array is not changed.
- R5: Command decoding compares only address bits 10..0 with 555 or 2AA, so unlock writes at any upper address are accepted.
- R6: The sequence AA@555, 55@2AA, 80@555, AA@555, 55@2AA, 10@555 sets every byte of every sector to FF once the busy phase ends.
- R7: Replacing the last erase write with 30 at a sector address selects the sector in address bits 18..16. Each further 30 written within WIN_CYC clocks adds that sector and restarts the window. Only the selected sectors become FF; the other sectors keep their data.
- R8: Status bit 7 is the inverse of bit 7 of the target data. For an erase the target data is FF, so the bit reads 0.
- R9: Status bit 6 inverts on every status read. Bit 2 equals bit 6 during erase and is 0 during program. Bits 4, 1 and 0 read 0.
- R10: Status bit 3 reads 0 during the sector-erase window and during a program. It reads 1 once an erase is busy.
- R11: A program whose data has a 1 where the stored byte has a 0 leaves the array unchanged. Status then reads with bit 5 set, and keeps doing so on every read until F0 is written.
- R12: After reset, rdata is 00, every array byte is FF and the device is in read mode. rdata is registered: it changes only on the edge that samples a read and holds otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Chip select |
| wr | input | 1 | Write strobe, qualified by cs |
| rd | input | 1 | Read strobe, qualified by cs |
| addr | input | 19 | Byte address |
| wdata | input | 8 | Write data or command byte |
| rdata | output | 8 | Registered read data or status |

## Verification
The bench goes after the cycle where a program completes; a completion counter that is off by one would hand back array data one read early or one read late. It also targets a program that raises a bit, which a faulty design would silently store or allow to clear without a reset. Further cases are a broken or aborted unlock sequence, which a lax decoder would let through to program the array, and unlock writes at high addresses, which a decoder comparing too many address bits would refuse. In a two-sector erase, a design that dropped the window restart or decoded the wrong sector bits would erase too little or too much. Status reads are compared bit by bit for the toggle, inverted-data, erase-started and error flags.

// File: rtl/nor_cmd_flash.sv
module nor_cmd_flash #(
  parameter int unsigned SEC_AW   = 5,
  parameter int unsigned BUSY_CYC = 16,
  parameter int unsigned WIN_CYC  = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cs,
  input  logic        wr,
  input  logic        rd,
  input  logic [18:0] addr,
  input  logic [7:0]  wdata,
  output logic [7:0]  rdata
);
  localparam int unsigned IW    = SEC_AW + 3;
  localparam int unsigned DEPTH = 1 << IW;

  typedef enum logic [3:0] {
    S_RD, S_U1, S_U2, S_PG, S_E1, S_E2, S_E3, S_WIN, S_BSY, S_ERR
  } st_t;

  st_t         st;
  int unsigned cnt;
  logic        op_erase, tog;
  logic [7:0]  smask, tgt_dat;
  logic [IW-1:0] tgt_idx;
  logic [7:0]  mem [DEPTH];

  wire           we     = cs & wr;
  wire           re     = cs & rd;
  wire           is555  = addr[10:0] == 11'h555;
  wire           is2aa  = addr[10:0] == 11'h2AA;
  wire [IW-1:0]  idx    = {addr[18:16], addr[SEC_AW-1:0]};
  wire [7:0]     sec1h  = 8'b1 << addr[18:16];
  wire           smode  = (st == S_WIN) || (st == S_BSY) || (st == S_ERR);
  wire [7:0]     status = {~tgt_dat[7], tog, st == S_ERR, 1'b0,
                           (st == S_BSY) && op_erase, op_erase & tog, 2'b00};

  logic unused_hi;
  assign unused_hi = &{1'b0, addr[15:11]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_RD;
      cnt      <= 0;
      op_erase <= 1'b0;
      tog      <= 1'b0;
      smask    <= '0;
      tgt_dat  <= '0;
      tgt_idx  <= '0;
      rdata    <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else begin
      if (re) begin
        if (smode) begin
          rdata <= status;
          tog   <= ~tog;
        end else begin
          rdata <= mem[idx];
        end
      end
      case (st)
        S_RD:  if (we && is555 && wdata == 8'hAA) st <= S_U1;
        S_U1:  if (we) st <= (is2aa && wdata == 8'h55) ? S_U2 : S_RD;
        S_U2:  if (we) begin
                 if (is555 && wdata == 8'hA0)      st <= S_PG;
                 else if (is555 && wdata == 8'h80) st <= S_E1;
                 else                              st <= S_RD;
               end
        S_PG:  if (we) begin
                 tgt_idx  <= idx;
                 tgt_dat  <= wdata;
                 op_erase <= 1'b0;
                 cnt      <= BUSY_CYC - 1;
                 st       <= ((wdata & ~mem[idx]) != 8'h00) ? S_ERR : S_BSY;
               end
        S_E1:  if (we) st <= (is555 && wdata == 8'hAA) ? S_E2 : S_RD;
        S_E2:  if (we) st <= (is2aa && wdata == 8'h55) ? S_E3 : S_RD;
        S_E3:  if (we) begin
                 if (is555 && wdata == 8'h10) begin
                   smask <= 8'hFF; op_erase <= 1'b1; tgt_dat <= 8'hFF;
                   cnt   <= BUSY_CYC - 1; st <= S_BSY;
                 end else if (wdata == 8'h30) begin
                   smask <= sec1h; op_erase <= 1'b1; tgt_dat <= 8'hFF;
                   cnt   <= WIN_CYC - 1; st <= S_WIN;
                 end else begin
                   st <= S_RD;
                 end
               end
        S_WIN: if (we && wdata == 8'h30) begin
                 smask <= smask | sec1h;
                 cnt   <= WIN_CYC - 1;
               end else if (cnt == 0) begin
                 cnt <= BUSY_CYC - 1;
                 st  <= S_BSY;
               end else begin
                 cnt <= cnt - 1;
               end
        S_BSY: if (cnt == 0) begin
                 st <= S_RD;
                 if (op_erase) begin
                   for (int i = 0; i < DEPTH; i++)
                     if (smask[3'(i >> SEC_AW)]) mem[i] <= 8'hFF;
                 end else begin
                   mem[tgt_idx] <= mem[tgt_idx] & tgt_dat;
                 end
               end else begin
                 cnt <= cnt - 1;
               end
        S_ERR: if (we && wdata == 8'hF0) st <= S_RD;
        default: st <= S_RD;
      endcase
    end
  end
endmodule

// File: rtl/nor_cmd_flash_chk.sv
module nor_cmd_flash_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs,
  input logic       wr,
  input logic       rd,
  input logic [7:0] wdata,
  input logic [7:0] rdata,
  input logic       in_rd,
  input logic       in_cmd,
  input logic       in_win,
  input logic       in_bsy,
  input logic       in_err,
  input logic       cnt_zero,
  input logic       tog,
  input logic       tgt7
);
  wire smode = in_win | in_bsy | in_err;

  a_r2_busy_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (in_bsy && cnt_zero) |=> in_rd);
  a_r3_f0_to_read: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && wr && wdata == 8'hF0 && (in_cmd || in_err)) |=> in_rd);
  a_r7_window_closes: assert property (@(posedge clk) disable iff (!rst_n)
    (in_win && cnt_zero && !(cs && wr && wdata == 8'h30)) |=> in_bsy);
  a_r8_d7_inverted: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && rd && in_bsy) |=> rdata[7] != $past(tgt7));
  a_r9_toggle_flips: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && rd && smode) |=> tog != $past(tog));
  a_r11_error_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (in_err && !(cs && wr && wdata == 8'hF0)) |=> in_err);
  a_r12_rdata_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !(cs && rd) |=> $stable(rdata));
endmodule

bind nor_cmd_flash nor_cmd_flash_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs(cs), .wr(wr), .rd(rd),
  .wdata(wdata), .rdata(rdata),
  .in_rd(st == S_RD),
  .in_cmd(st == S_U1 || st == S_U2 || st == S_E1 || st == S_E2 || st == S_E3),
  .in_win(st == S_WIN), .in_bsy(st == S_BSY), .in_err(st == S_ERR),
  .cnt_zero(cnt == 0), .tog(tog), .tgt7(tgt_dat[7])
);

// File: tb/tb_nor_cmd_flash.sv
module tb_nor_cmd_flash;
  localparam int CLK_PERIOD = 10;
  localparam int SA = 5;
  localparam int B  = 12;
  localparam int W  = 6;

  logic clk = 0, rst_n = 0, cs = 0, wr = 0, rd = 0;
  logic [18:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  int checks = 0, fails = 0;
  bit done = 0;

  nor_cmd_flash #(.SEC_AW(SA), .BUSY_CYC(B), .WIN_CYC(W)) dut (
    .clk(clk), .rst_n(rst_n), .cs(cs), .wr(wr), .rd(rd),
    .addr(addr), .wdata(wdata), .rdata(rdata));

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference: 0 read,1-2 unlock,3 data,4-6 erase unlock,7 window,8 busy,9 error
  int ms, mcnt;
  bit mer, mtog;
  logic [7:0] msm, mtd, exp_rd;
  int mti;
  logic [7:0] mm [256];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ms = 0; mcnt = 0; mer = 0; mtog = 0; msm = 0; mtd = 0; mti = 0; exp_rd = 0;
      for (int i = 0; i < 256; i++) mm[i] = 8'hFF;
    end else begin
      automatic int i = {addr[18:16], addr[SA-1:0]};
      automatic bit a5 = addr[10:0] == 11'h555;
      automatic bit a2 = addr[10:0] == 11'h2AA;
      automatic bit w = cs && wr;
      if (cs && rd) begin
        if (ms >= 7) begin
          exp_rd = {~mtd[7], mtog, ms == 9, 1'b0, ms == 8 && mer, mer && mtog, 2'b00};
          mtog = ~mtog;
        end else exp_rd = mm[i];
      end
      if (ms == 7) begin
        if (w && wdata == 8'h30) begin msm[addr[18:16]] = 1; mcnt = W - 1; end
        else if (mcnt == 0) begin ms = 8; mcnt = B - 1; end
        else mcnt--;
      end else if (ms == 8) begin
        if (mcnt == 0) begin
          ms = 0;
          if (mer) begin
            for (int k = 0; k < 256; k++) if (msm[k / 32]) mm[k] = 8'hFF;
          end else mm[mti] = mm[mti] & mtd;
        end else mcnt--;
      end else if (ms == 9) begin
        if (w && wdata == 8'hF0) ms = 0;
      end else if (w) begin
        if (ms == 0) ms = (a5 && wdata == 8'hAA) ? 1 : 0;
        else if (ms == 1) ms = (a2 && wdata == 8'h55) ? 2 : 0;
        else if (ms == 2) ms = (a5 && wdata == 8'hA0) ? 3 : (a5 && wdata == 8'h80) ? 4 : 0;
        else if (ms == 3) begin
          mti = i; mtd = wdata; mer = 0; mcnt = B - 1;
          ms = ((wdata & ~mm[i]) != 0) ? 9 : 8;
        end
        else if (ms == 4) ms = (a5 && wdata == 8'hAA) ? 5 : 0;
        else if (ms == 5) ms = (a2 && wdata == 8'h55) ? 6 : 0;
        else if (ms == 6) begin
          mer = 1; mtd = 8'hFF;
          if (a5 && wdata == 8'h10) begin msm = 8'hFF; mcnt = B - 1; ms = 8; end
          else if (wdata == 8'h30) begin msm = 0; msm[addr[18:16]] = 1; mcnt = W - 1; ms = 7; end
          else ms = 0;
        end
      end
    end
  end

  always @(negedge clk) if (rst_n && !done) begin
    checks++;
    if (rdata !== exp_rd) begin
      fails++;
      $display("FAIL R2 model compare @%0t: rdata=%02h expected=%02h", $time, rdata, exp_rd);
    end
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, act, expv);
    end
  endtask

  task automatic bw(input logic [18:0] a, input logic [7:0] d);
    cs = 1; wr = 1; rd = 0; addr = a; wdata = d;
    @(negedge clk);
    cs = 0; wr = 0;
  endtask

  task automatic br(input logic [18:0] a, output logic [7:0] v);
    cs = 1; rd = 1; wr = 0; addr = a;
    @(negedge clk);
    v = rdata;
    cs = 0; rd = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic prog(input logic [18:0] a, input logic [7:0] d);
    bw(19'h00555, 8'hAA); bw(19'h002AA, 8'h55); bw(19'h00555, 8'hA0); bw(a, d);
  endtask

  task automatic erase5;
    bw(19'h00555, 8'hAA); bw(19'h002AA, 8'h55); bw(19'h00555, 8'h80);
    bw(19'h00555, 8'hAA); bw(19'h002AA, 8'h55);
  endtask

  task automatic finish_run;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: actual=hung expected=finished");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    idle(2);
    rst_n = 1;
    chk("R12 rdata after reset", rdata, 8'h00);
    br(19'h00000, v); chk("R12 erased array", v, 8'hFF);

    // R1 / R2 / R8 / R9: program and poll every cycle
    prog(19'h00010, 8'h3C);
    for (int k = 1; k <= B + 1; k++) begin
      br(19'h00010, v);
      if (k <= B) chk("R8 R9 program status", v, 8'h80 | 8'(((k - 1) & 1) << 6));
      else        chk("R2 data after busy", v, 8'h3C);
    end
    br(19'h00010, v); chk("R1 stored byte", v, 8'h3C);

    // R11: raising bits fails and sticks
    prog(19'h00010, 8'h0F);
    br(19'h00010, v); chk("R11 error status", v, 8'hA0);
    br(19'h00010, v); chk("R11 error toggle", v, 8'hE0);
    idle(3 * B);
    br(19'h00010, v); chk("R11 error persists", v, 8'hA0);
    bw(19'h12345, 8'hF0);
    br(19'h00010, v); chk("R11 array unchanged", v, 8'h3C);

    // R5: unlock at high addresses, AND programming
    bw(19'h7F555, 8'hAA); bw(19'h3FAAA, 8'h55); bw(19'h5D555, 8'hA0); bw(19'h00010, 8'h0C);
    idle(B + 2);
    br(19'h00010, v); chk("R5 high-address unlock programs", v, 8'h0C);

    // R4: wrong unlock address aborts
    bw(19'h00555, 8'hAA); bw(19'h002AB, 8'h55); bw(19'h00555, 8'hA0); bw(19'h00010, 8'h00);
    br(19'h00010, v); chk("R4 mismatch ignored", v, 8'h0C);

    // R3: F0 mid-sequence
    bw(19'h00555, 8'hAA); bw(19'h002AA, 8'h55); bw(19'h00000, 8'hF0);
    bw(19'h00555, 8'hA0); bw(19'h00010, 8'h00);
    br(19'h00010, v); chk("R3 reset mid-sequence", v, 8'h0C);

    // R7 / R10: two-sector erase
    prog(19'h10005, 8'h00); idle(B + 2);
    prog(19'h20001, 8'h11); idle(B + 2);
    prog(19'h30000, 8'h22); idle(B + 2);
    erase5();
    bw(19'h00000, 8'h30);
    bw(19'h10000, 8'h30);
    br(19'h00000, v);
    chk("R10 window D3 and D7", v & 8'h88, 8'h00);
    chk("R9 D2 follows D6", {7'b0, v[2]}, {7'b0, v[6]});
    chk("R9 unused status bits", v & 8'h33, 8'h00);
    idle(W + 1);
    br(19'h00000, v);
    chk("R10 erase busy D3", v & 8'h88, 8'h08);
    idle(B + 2);
    br(19'h00010, v); chk("R7 sector 0 erased", v, 8'hFF);
    br(19'h10005, v); chk("R7 sector 1 erased", v, 8'hFF);
    br(19'h20001, v); chk("R7 sector 2 kept", v, 8'h11);
    br(19'h30000, v); chk("R7 sector 3 kept", v, 8'h22);

    // R6: chip erase
    erase5();
    bw(19'h00555, 8'h10);
    br(19'h00000, v); chk("R10 chip erase busy", v & 8'hA8, 8'h08);
    idle(B + 2);
    br(19'h20001, v); chk("R6 chip erase sector 2", v, 8'hFF);
    br(19'h30000, v); chk("R6 chip erase sector 3", v, 8'hFF);
    br(19'h7001F, v); chk("R6 chip erase sector 7", v, 8'hFF);

    idle(3);
    finish_run();
  end
endmodule